// File: doc/BRIEF.md
# Line-Counted Frame Sync Generator

This block produces a periodic frame-sync level for a video-port capture engine that is being used to take in a raw transport stream instead of pictures. Received bytes arrive as single-cycle strobes. The block groups them into lines of a fixed byte count (two 188-byte packets, 376 bytes, by default). It then groups the lines into frames whose length is a software-written line threshold, 512 by default. An internal frame event is high for exactly the last line of each frame. The sync output follows that event one clock later, so the capture engine sees one high pulse, one line long, per frame of buffered data.

A second mode lets host software confirm that the sync output is wired back to the capture engine's vertical-blank input. Software arms the check, which drives the output low. It then raises the output. The block waits for the first rising edge seen on the loopback input and drops the output once, then stops reacting. If software later reads the line low, the loopback is present. If it reads the line still high, the loopback is missing. A frame counter output counts every rising edge of the sync so that delivered bandwidth can be checked.

Top module: `line_sync_gen`

## Requirements
- R1: After reset, syncOut is 0, frameCount is 0 and the line threshold is 512.
- R2: A line is LINE_BYTES (default 376) cycles with byteValid high. Cycles with byteValid low do not advance the byte or line count.
- R3: With a threshold N, syncOut goes high one cycle after the last byte of line N-1 of a frame and stays high through line N. It goes low one cycle after the last byte of line N. This repeats every N lines for as long as generation is enabled.
- R4: A pulse on threshWr stores threshData (12 bits) when the value is 2 or more. Values 0 and 1 are ignored, and the old threshold is kept.
- R5: A stored threshold takes effect at the next frame boundary. While generation is disabled, it takes effect at once.
- R6: With runEnable low and detectMode low, syncOut is low from the next cycle on. Byte and line counts restart, so that after enable the first frame again starts at line 1.
- R7: frameCount increases by one on every cycle in which syncOut rises, in either mode.
- R8: In detect mode, detectArm drives syncOut low and arms the check. hostRaise drives syncOut high. The first rising edge of vblankIn while armed drives syncOut low and disarms, and later edges leave syncOut unchanged.
- R9: detectMode overrides runEnable. No bytes are counted in detect mode, and syncOut keeps the level software set while bytes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEnable | input | 1 | Enables frame-sync generation |
| detectMode | input | 1 | Selects the loopback detection mode |
| detectArm | input | 1 | Detection: drive low and arm |
| hostRaise | input | 1 | Detection: drive output high |
| byteValid | input | 1 | One received stream byte this cycle |
| threshWr | input | 1 | Write strobe for the line threshold |
| threshData | input | 12 | Line threshold value to write |
| vblankIn | input | 1 | Loopback of the sync as seen by the capture engine |
| syncOut | output | 1 | Frame-sync level |
| frameCount | output | 16 | Count of rising edges of syncOut |

## Verification
A byte or line counter that slips moves the rising edge of syncOut away from the exact byte position after line N-1. The directed tests sample syncOut on the cycle just before and just after that position, so an off-by-one shows within the same frame. A wrong active threshold changes the pulse spacing on the frame right after a write, and the tests measure that frame. A bad detect-mode arming shows as syncOut staying high or falling twice within a few cycles of hostRaise.

// File: rtl/line_sync_pkg.sv
package line_sync_pkg;
  // Strobes from the control half to the counting datapath
  typedef struct packed {
    logic countEn;   // accept this byte into the counters
    logic clear;     // restart counts and load the written threshold
    logic syncRise;  // sync output rises on this edge
  } syncStrobes_t;
endpackage

// File: rtl/line_sync_dp.sv
module line_sync_dp
  import line_sync_pkg::*;
#(
  parameter int LINE_BYTES = 376,
  parameter int THR_W      = 12,
  parameter int DEF_THRESH = 512,
  parameter int FRAME_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  syncStrobes_t       strobes,
  input  logic               threshWr,
  input  logic [THR_W-1:0]   threshData,
  output logic               frameEvent,
  output logic [FRAME_W-1:0] frameCount
);
  localparam int BYTE_W = (LINE_BYTES > 2) ? $clog2(LINE_BYTES) : 1;
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(LINE_BYTES - 1);
  localparam logic [THR_W-1:0]  MIN_THR   = THR_W'(2);

  logic [BYTE_W-1:0] byteCnt;
  logic [THR_W-1:0]  lineCnt;
  logic [THR_W-1:0]  threshReg;
  logic [THR_W-1:0]  activeThr;
  logic              lineEnd;
  logic              frameEnd;

  assign lineEnd    = strobes.countEn && (byteCnt == LAST_BYTE);
  assign frameEnd   = lineEnd && (lineCnt == activeThr - 1'b1);
  assign frameEvent = (lineCnt == activeThr - 1'b1);

  // Written threshold; values below two are dropped
  always_ff @(posedge clk) begin
    if (!rstN) threshReg <= THR_W'(DEF_THRESH);
    else if (threshWr && threshData >= MIN_THR) threshReg <= threshData;
  end

  // Byte and line counters with the frame-boundary threshold load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt   <= '0;
      lineCnt   <= '0;
      activeThr <= THR_W'(DEF_THRESH);
    end else if (strobes.clear) begin
      byteCnt   <= '0;
      lineCnt   <= '0;
      activeThr <= threshReg;
    end else if (strobes.countEn) begin
      byteCnt <= lineEnd ? '0 : byteCnt + 1'b1;
      if (frameEnd) begin
        lineCnt   <= '0;
        activeThr <= threshReg;
      end else if (lineEnd) begin
        lineCnt <= lineCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) frameCount <= '0;
    else if (strobes.syncRise) frameCount <= frameCount + 1'b1;
  end

  a_r2_byte_bound: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= LAST_BYTE);
  a_r3_line_bound: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt < activeThr);
  a_r4_thresh_floor: assert property (@(posedge clk) disable iff (!rstN)
    threshReg >= MIN_THR);
  a_r5_load_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clear && !frameEnd) |=> $stable(activeThr));
  a_r7_frame_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.syncRise |=> frameCount == $past(frameCount) + 1'b1);
endmodule

// File: rtl/line_sync_ctl.sv
module line_sync_ctl
  import line_sync_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         runEnable,
  input  logic         detectMode,
  input  logic         detectArm,
  input  logic         hostRaise,
  input  logic         byteValid,
  input  logic         vblankIn,
  input  logic         frameEvent,
  output syncStrobes_t strobes,
  output logic         syncOut
);
  logic armed;
  logic armedNext;
  logic syncNext;
  logic vbPrev;
  logic vbRise;

  assign vbRise = vblankIn && !vbPrev;

  always_comb begin
    syncNext  = syncOut;
    armedNext = armed;
    if (detectMode) begin
      if (detectArm) begin
        syncNext  = 1'b0;
        armedNext = 1'b1;
      end else if (hostRaise) begin
        syncNext = 1'b1;
      end else if (armed && vbRise) begin
        syncNext  = 1'b0;
        armedNext = 1'b0;
      end
    end else begin
      syncNext  = runEnable && frameEvent;
      armedNext = 1'b0;
    end
  end

  always_comb begin
    strobes.countEn  = !detectMode && runEnable && byteValid;
    strobes.clear    = detectMode || !runEnable;
    strobes.syncRise = syncNext && !syncOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncOut <= 1'b0;
      armed   <= 1'b0;
      vbPrev  <= 1'b0;
    end else begin
      syncOut <= syncNext;
      armed   <= armedNext;
      vbPrev  <= vblankIn;
    end
  end

  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (!detectMode && !runEnable) |=> !syncOut);
  a_r8_detect_hold: assert property (@(posedge clk) disable iff (!rstN)
    (detectMode && !armed && !hostRaise && !detectArm) |=> $stable(syncOut));
  a_r9_no_count_in_detect: assert property (@(posedge clk) disable iff (!rstN)
    detectMode |-> !strobes.countEn);
endmodule

// File: rtl/line_sync_gen.sv
module line_sync_gen
  import line_sync_pkg::*;
#(
  parameter int LINE_BYTES = 376,
  parameter int THR_W      = 12,
  parameter int DEF_THRESH = 512,
  parameter int FRAME_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               runEnable,
  input  logic               detectMode,
  input  logic               detectArm,
  input  logic               hostRaise,
  input  logic               byteValid,
  input  logic               threshWr,
  input  logic [THR_W-1:0]   threshData,
  input  logic               vblankIn,
  output logic               syncOut,
  output logic [FRAME_W-1:0] frameCount
);
  syncStrobes_t strobes;
  logic         frameEvent;

  line_sync_ctl uCtl (
    .clk(clk), .rstN(rstN), .runEnable(runEnable), .detectMode(detectMode),
    .detectArm(detectArm), .hostRaise(hostRaise), .byteValid(byteValid),
    .vblankIn(vblankIn), .frameEvent(frameEvent), .strobes(strobes),
    .syncOut(syncOut)
  );

  line_sync_dp #(
    .LINE_BYTES(LINE_BYTES), .THR_W(THR_W),
    .DEF_THRESH(DEF_THRESH), .FRAME_W(FRAME_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .threshWr(threshWr),
    .threshData(threshData), .frameEvent(frameEvent), .frameCount(frameCount)
  );
endmodule

// File: tb/line_sync_gen_test.sv
module line_sync_gen_test;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEnable = 1'b0, detectMode = 1'b0, detectArm = 1'b0, hostRaise = 1'b0;
  logic byteValid = 1'b0, threshWr = 1'b0, loopOn = 1'b0;
  logic [11:0] threshData = '0;
  logic vblankIn;
  logic syncOut;
  logic [15:0] frameCount;
  int checks = 0, errors = 0, expFrames = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  assign vblankIn = loopOn ? syncOut : 1'b0;

  line_sync_gen #(.LINE_BYTES(L)) uut (
    .clk(clk), .rstN(rstN), .runEnable(runEnable), .detectMode(detectMode),
    .detectArm(detectArm), .hostRaise(hostRaise), .byteValid(byteValid),
    .threshWr(threshWr), .threshData(threshData), .vblankIn(vblankIn),
    .syncOut(syncOut), .frameCount(frameCount)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushBytes(int n);
    byteValid = 1'b1;
    repeat (n) @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic pushGapped(int n);
    for (int i = 0; i < n; i++) begin
      byteValid = 1'b1; @(negedge clk);
      byteValid = 1'b0; @(negedge clk);
    end
  endtask

  task automatic writeThresh(int v);
    threshData = 12'(v); threshWr = 1'b1; @(negedge clk);
    threshWr = 1'b0;
  endtask

  // Frame of n lines from line 1: checks edge positions of the pulse
  task automatic frame(string req, int n);
    pushBytes((n - 1) * L - 1); idle(1);
    chk({req, " low before edge"}, syncOut, 0);
    pushBytes(1); idle(1);
    expFrames++;
    chk({req, " high at line N"}, syncOut, 1);
    pushBytes(L);
    chk({req, " high through line N"}, syncOut, 1);
    idle(1);
    chk({req, " low after line N"}, syncOut, 0);
  endtask

  task automatic testReset();
    chk("R1 reset sync", syncOut, 0);
    chk("R1 reset frames", frameCount, 0);
  endtask

  task automatic testDefault();
    runEnable = 1'b1;
    frame("R1 R3 default 512", 512);
    chk("R7 frames", frameCount, expFrames);
    runEnable = 1'b0; idle(1);
  endtask

  task automatic testThresh();
    writeThresh(3); writeThresh(1); writeThresh(0);
    runEnable = 1'b1;
    frame("R4 thresh 3, 0/1 ignored", 3);
    pushBytes(L);
    writeThresh(5);
    pushBytes(L); idle(1);
    expFrames++;
    chk("R5 old threshold kept mid-frame", syncOut, 1);
    pushBytes(L); idle(1);
    chk("R5 old frame ends", syncOut, 0);
    frame("R5 new threshold 5", 5);
    chk("R7 frames", frameCount, expFrames);
  endtask

  task automatic testGaps();
    pushGapped(4 * L - 1);
    chk("R2 gapped bytes low", syncOut, 0);
    pushGapped(1);
    expFrames++;
    chk("R2 gapped bytes edge", syncOut, 1);
    pushBytes(L); idle(1);
    chk("R2 gapped frame end", syncOut, 0);
  endtask

  task automatic testDisable();
    pushBytes(4 * L); idle(1);
    expFrames++;
    chk("R6 pulse before disable", syncOut, 1);
    runEnable = 1'b0; idle(1);
    chk("R6 disabled low", syncOut, 0);
    idle(3);
    chk("R6 still low", syncOut, 0);
    runEnable = 1'b1;
    frame("R6 restart at line 1", 5);
    chk("R7 frames", frameCount, expFrames);
    runEnable = 1'b0; idle(1);
  endtask

  task automatic pulseArm();
    detectArm = 1'b1; @(negedge clk); detectArm = 1'b0;
  endtask

  task automatic pulseRaise();
    hostRaise = 1'b1; @(negedge clk); hostRaise = 1'b0;
  endtask

  task automatic testDetectLoop();
    loopOn = 1'b1; detectMode = 1'b1;
    pulseArm();
    chk("R8 armed low", syncOut, 0);
    pulseRaise();
    expFrames++;
    chk("R8 raised", syncOut, 1);
    chk("R7 frame on raise", frameCount, expFrames);
    idle(1);
    chk("R8 loopback dropped", syncOut, 0);
    pulseRaise();
    expFrames++;
    idle(3);
    chk("R8 one-shot, later edge ignored", syncOut, 1);
    chk("R7 frames", frameCount, expFrames);
  endtask

  task automatic testDetectNoLoop();
    loopOn = 1'b0; runEnable = 1'b1;
    pulseArm();
    chk("R8 arm low", syncOut, 0);
    pulseRaise();
    expFrames++;
    idle(5);
    chk("R8 no loopback stays high", syncOut, 1);
    pushBytes(6 * L);
    chk("R9 bytes ignored in detect", syncOut, 1);
    detectMode = 1'b0; idle(1);
    chk("R9 run after detect low", syncOut, 0);
    frame("R9 counts restart after detect", 5);
    chk("R7 frames", frameCount, expFrames);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(1);
    testReset();
    testDefault();
    testThresh();
    testGaps();
    testDisable();
    testDetectLoop();
    testDetectNoLoop();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule